// File: doc/BRIEF.md
# Four-Plane Graphics Byte Datapath

This block sits between a host and four byte-wide bit planes of display memory. Every host byte access touches the same address in all four planes at once. On a write, the block forms one new byte per plane from the host byte, a per-plane constant colour, the 32-bit latch and an 8-bit bit mask. It also drives a per-plane write enable. On a read, it captures all four plane bytes into the latch. It then returns either the byte of one chosen plane or a colour-match byte.

Configuration lives in ten 8-bit registers reached indirectly. The host first writes a register number through the index strobe. It then writes or reads that register through the data strobe. A small controller with three states sequences each access: ST_IDLE, ST_WRITE (plane outputs presented) and ST_READ (read result presented). From any state the controller takes one of three transitions. It goes to ST_WRITE when a host write is accepted, to ST_READ when only a host read is accepted, and to ST_IDLE otherwise.

Top module: `plane_gfx_datapath`

## Requirements
- R1: `idx_wr` loads `bus_wdata[3:0]` as the register number. `data_wr` then writes `bus_wdata` to that register. `bus_rdata` shows the selected register from the cycle after the write. Numbers 10 to 15 select nothing: writes to them are dropped and reads return 0.
- R2: After reset, `mem_we` is 0 and `host_rvalid` is 0. The plane-enable register (9) reads 0x0F and the bit mask (8) reads 0xFF. The registers for colour (0), colour enable (1), rotate/function (3) and mode (5) read 0.
- R3: Write mode 0 (register 5 bits [1:0] = 0) right-rotates the host byte by register 3 bits [2:0]. Each plane p whose register 1 bit p is 1 uses 0xFF or 0x00 instead, chosen by register 0 bit p.
- R4: Register 3 bits [4:3] pick the function applied against that plane's latch byte: 0 passes the data, 1 ANDs it, 2 ORs it, 3 XORs it.
- R5: Write mode 1 writes each plane's latch byte unchanged. The function and the bit mask have no effect in this mode.
- R6: Write mode 2 turns host bit p into 0xFF or 0x00 for plane p before the function and the mask.
- R7: Write mode 3 takes plane p's data from register 0 bit p (0xFF or 0x00). The mask used is the rotated host byte ANDed with register 8.
- R8: In modes 0, 2 and 3, a mask bit of 0 keeps the latch bit. Mask bit n selects bit n of every plane byte.
- R9: One cycle after a host write, `mem_we` equals register 9 bits [3:0], with bit p for plane p. Plane p's byte is `mem_wdata[8p+7:8p]`. At any other time `mem_we` is 0.
- R10: A host read loads all four latch bytes from `mem_rdata`. One cycle later, `host_rvalid` is 1. When register 5 bit 3 is 0, `host_rdata` is the byte of the plane picked by register 4 bits [1:0].
- R11: When register 5 bit 3 is 1, `host_rdata` bit n is 1 when plane p's bit n equals register 2 bit p for every plane p whose register 7 bit p is 1. Other planes do not take part.
- R12: If `host_wr` and `host_rd` are both high in one cycle, only the write is done. No read result is given and the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Load register number from bus_wdata |
| data_wr | input | 1 | Write bus_wdata to selected register |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Selected register contents |
| host_wr | input | 1 | Host byte write request |
| host_rd | input | 1 | Host byte read request |
| host_wdata | input | 8 | Host write byte |
| mem_rdata | input | 32 | Four plane bytes at the accessed address |
| mem_wdata | output | 32 | Four plane bytes to store |
| mem_we | output | 4 | Per-plane write enable |
| host_rdata | output | 8 | Host read result |
| host_rvalid | output | 1 | host_rdata valid |

## Verification
Plane bytes, write enables and read results all appear exactly one cycle after the clock edge that accepts the access. Register contents appear on the data port one cycle after the index is loaded. Each driver task stores the cycle in which its expected item falls due. The monitor compares the outputs at the falling edge of that cycle only. In every other cycle it expects the enables and the valid flag to be low. Each access is followed by an idle cycle, so the modelled memory is updated before the next access reads it.

// File: rtl/gc_pkg.sv
package gc_pkg;
    localparam int unsigned GC_NPLANES = 4;
    localparam int unsigned GC_DW      = 8;
    localparam int unsigned GC_NREGS   = 10;
    localparam int unsigned GC_IDXW    = 4;
    localparam int unsigned GC_SELW    = $clog2(GC_NPLANES);

    localparam int unsigned IX_COLOR    = 0;
    localparam int unsigned IX_COLOR_EN = 1;
    localparam int unsigned IX_MATCH    = 2;
    localparam int unsigned IX_ROTFN    = 3;
    localparam int unsigned IX_RDSEL    = 4;
    localparam int unsigned IX_MODE     = 5;
    localparam int unsigned IX_CARE     = 7;
    localparam int unsigned IX_BITMASK  = 8;
    localparam int unsigned IX_PLANE_EN = 9;

    typedef enum logic [1:0] {FN_PASS, FN_AND, FN_OR, FN_XOR} gc_fn_e;
    typedef enum logic [1:0] {WM_HOST, WM_LATCH, WM_COLOR, WM_MASKED} gc_wmode_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} gc_state_e;

    typedef struct packed {
        logic [GC_NPLANES-1:0] plane_en;
        logic [GC_NPLANES-1:0] color;
        logic [GC_NPLANES-1:0] color_en;
        logic [GC_NPLANES-1:0] match;
        logic [GC_NPLANES-1:0] care;
        logic [GC_DW-1:0]      bitmask;
        logic [2:0]            rot_cnt;
        gc_fn_e                fn;
        logic [GC_SELW-1:0]    rd_sel;
        gc_wmode_e             wmode;
        logic                  rd_cmp;
    } gc_cfg_t;
endpackage

// File: rtl/gc_regfile.sv
module gc_regfile
    import gc_pkg::*;
#(
    parameter int unsigned NREGS = GC_NREGS,
    parameter int unsigned IDXW  = GC_IDXW,
    parameter int unsigned DW    = GC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output gc_cfg_t       cfg
);
    logic [IDXW-1:0] idx_q;
    logic [DW-1:0]   regs_q [NREGS];

    function automatic logic [DW-1:0] reset_value(input int unsigned n);
        if (n == IX_BITMASK)  return '1;
        if (n == IX_PLANE_EN) return DW'({GC_NPLANES{1'b1}});
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int unsigned n = 0; n < NREGS; n++) begin
                regs_q[n] <= reset_value(n);
            end
        end else begin
            if (idx_wr) begin
                idx_q <= wdata[IDXW-1:0];
            end
            if (data_wr && (int'(idx_q) < int'(NREGS))) begin
                regs_q[idx_q] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(idx_q) < int'(NREGS)) begin
            rdata = regs_q[idx_q];
        end
    end

    always_comb begin
        cfg.plane_en = regs_q[IX_PLANE_EN][GC_NPLANES-1:0];
        cfg.color    = regs_q[IX_COLOR][GC_NPLANES-1:0];
        cfg.color_en = regs_q[IX_COLOR_EN][GC_NPLANES-1:0];
        cfg.match    = regs_q[IX_MATCH][GC_NPLANES-1:0];
        cfg.care     = regs_q[IX_CARE][GC_NPLANES-1:0];
        cfg.bitmask  = regs_q[IX_BITMASK];
        cfg.rot_cnt  = regs_q[IX_ROTFN][2:0];
        cfg.fn       = gc_fn_e'(regs_q[IX_ROTFN][4:3]);
        cfg.rd_sel   = regs_q[IX_RDSEL][GC_SELW-1:0];
        cfg.wmode    = gc_wmode_e'(regs_q[IX_MODE][1:0]);
        cfg.rd_cmp   = regs_q[IX_MODE][3];
    end
endmodule

// File: rtl/gc_write_path.sv
module gc_write_path
    import gc_pkg::*;
#(
    parameter int unsigned NPLANES = GC_NPLANES,
    parameter int unsigned DW      = GC_DW
) (
    input  gc_cfg_t                cfg,
    input  logic [DW-1:0]          host_data,
    input  logic [NPLANES*DW-1:0]  latch,
    output logic [NPLANES*DW-1:0]  plane_out
);
    logic [DW-1:0] rotated;
    logic [DW-1:0] eff_mask;

    // Right rotate: the low half of the doubled byte shifted right.
    assign rotated  = DW'({host_data, host_data} >> cfg.rot_cnt);
    assign eff_mask = (cfg.wmode == WM_MASKED) ? (rotated & cfg.bitmask) : cfg.bitmask;

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        logic [DW-1:0] lat;
        logic [DW-1:0] src;
        logic [DW-1:0] alu;

        assign lat = latch[p*DW +: DW];

        always_comb begin
            unique case (cfg.wmode)
                WM_HOST:   src = cfg.color_en[p] ? {DW{cfg.color[p]}} : rotated;
                WM_COLOR:  src = {DW{host_data[p]}};
                WM_MASKED: src = {DW{cfg.color[p]}};
                default:   src = rotated;
            endcase
        end

        always_comb begin
            unique case (cfg.fn)
                FN_AND:  alu = src & lat;
                FN_OR:   alu = src | lat;
                FN_XOR:  alu = src ^ lat;
                default: alu = src;
            endcase
        end

        assign plane_out[p*DW +: DW] = (cfg.wmode == WM_LATCH) ? lat
                                     : ((alu & eff_mask) | (lat & ~eff_mask));
    end
endmodule

// File: rtl/gc_read_path.sv
module gc_read_path
    import gc_pkg::*;
#(
    parameter int unsigned NPLANES = GC_NPLANES,
    parameter int unsigned DW      = GC_DW
) (
    input  gc_cfg_t               cfg,
    input  logic [NPLANES*DW-1:0] planes,
    output logic [DW-1:0]         rd_byte
);
    logic [DW-1:0] sel_byte;
    logic [DW-1:0] cmp_byte;

    assign sel_byte = planes[cfg.rd_sel*DW +: DW];

    for (genvar b = 0; b < DW; b++) begin : g_bit
        always_comb begin
            cmp_byte[b] = 1'b1;
            for (int p = 0; p < NPLANES; p++) begin
                if (cfg.care[p] && (planes[p*DW + b] != cfg.match[p])) begin
                    cmp_byte[b] = 1'b0;
                end
            end
        end
    end

    assign rd_byte = cfg.rd_cmp ? cmp_byte : sel_byte;
endmodule

// File: rtl/plane_gfx_datapath.sv
module plane_gfx_datapath
    import gc_pkg::*;
#(
    parameter int unsigned NPLANES = GC_NPLANES,
    parameter int unsigned DW      = GC_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_wr,
    input  logic                  data_wr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [DW-1:0]         host_wdata,
    input  logic [NPLANES*DW-1:0] mem_rdata,
    output logic [NPLANES*DW-1:0] mem_wdata,
    output logic [NPLANES-1:0]    mem_we,
    output logic [DW-1:0]         host_rdata,
    output logic                  host_rvalid
);
    localparam int unsigned BUSW = NPLANES * DW;

    gc_cfg_t          cfg_w;
    logic [BUSW-1:0]  latch_q;
    logic [BUSW-1:0]  wr_bytes;
    logic [DW-1:0]    rd_byte;
    logic [BUSW-1:0]  wdata_q;
    logic [NPLANES-1:0] we_q;
    logic [DW-1:0]    rdata_q;
    logic [NPLANES-1:0] plane_en_w;
    logic             rd_accept;
    gc_state_e        state_q;
    gc_state_e        state_d;

    assign plane_en_w = cfg_w.plane_en[NPLANES-1:0];
    assign rd_accept  = host_rd && !host_wr;

    gc_regfile #(.NREGS(GC_NREGS), .IDXW(GC_IDXW), .DW(DW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .cfg     (cfg_w)
    );

    gc_write_path #(.NPLANES(NPLANES), .DW(DW)) i_wpath (
        .cfg       (cfg_w),
        .host_data (host_wdata),
        .latch     (latch_q),
        .plane_out (wr_bytes)
    );

    gc_read_path #(.NPLANES(NPLANES), .DW(DW)) i_rpath (
        .cfg     (cfg_w),
        .planes  (mem_rdata),
        .rd_byte (rd_byte)
    );

    // Next-state selection: every state leaves on the same three transitions.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_READ: begin
                if (host_wr)        state_d = ST_WRITE;
                else if (host_rd)   state_d = ST_READ;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            wdata_q <= '0;
            we_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (host_wr) begin
                wdata_q <= wr_bytes;
                we_q    <= plane_en_w;
            end
            if (rd_accept) begin
                latch_q <= mem_rdata;
                rdata_q <= rd_byte;
            end
        end
    end

    always_comb begin
        mem_we      = '0;
        mem_wdata   = '0;
        host_rdata  = '0;
        host_rvalid = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                mem_we    = we_q;
                mem_wdata = wdata_q;
            end
            ST_READ: begin
                host_rvalid = 1'b1;
                host_rdata  = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gc_checker.sv
module gc_checker #(
    parameter int unsigned NPLANES = 4,
    parameter int unsigned DW      = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_wr,
    input logic                  host_rd,
    input logic [NPLANES-1:0]    plane_en,
    input logic [1:0]            wmode,
    input logic [DW-1:0]         bitmask,
    input logic [NPLANES*DW-1:0] latch,
    input logic [NPLANES-1:0]    mem_we,
    input logic [NPLANES*DW-1:0] mem_wdata,
    input logic                  host_rvalid
);
    assert_we_matches_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_wr) |-> (mem_we == $past(plane_en)));

    assert_no_stray_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_wr) |-> (mem_we == '0));

    assert_rvalid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> ($past(host_rd) && !$past(host_wr)));

    assert_write_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_wr) && $past(host_rd)) |-> !host_rvalid);

    assert_latch_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_wr) && ($past(wmode) == 2'd1)) |-> (mem_wdata == $past(latch)));

    assert_mask_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_wr) && (($past(wmode) == 2'd0) || ($past(wmode) == 2'd2)))
        |-> (((mem_wdata ^ $past(latch)) & ~{NPLANES{$past(bitmask)}}) == '0));
endmodule

bind plane_gfx_datapath gc_checker #(.NPLANES(NPLANES), .DW(DW)) i_gc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .plane_en    (plane_en_w),
    .wmode       (cfg_w.wmode),
    .bitmask     (cfg_w.bitmask),
    .latch       (latch_q),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .host_rvalid (host_rvalid)
);

// File: tb/test_plane_gfx_datapath.sv
`timescale 1ns/1ps
module test_plane_gfx_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0, data_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_we;
    logic [7:0]  host_rdata;
    logic        host_rvalid;

    always #2 clk = ~clk;

    plane_gfx_datapath i_plane_gfx_datapath (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid)
    );

    typedef struct {
        bit          is_rd;
        int          due;
        logic [31:0] data;
        logic [3:0]  we;
        int          addr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 0;
    logic [7:0]  mem [4][16];
    logic [7:0]  m_regs [16];
    logic [31:0] m_latch = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] mdl_write(input logic [7:0] d);
        logic [15:0] dd;
        logic [7:0]  rot, emask, src, alu, lat;
        logic [31:0] out;
        logic [1:0]  wm, fn;
        dd = {d, d} >> m_regs[3][2:0];
        rot = dd[7:0];
        wm = m_regs[5][1:0];
        fn = m_regs[3][4:3];
        emask = (wm == 2'd3) ? (rot & m_regs[8]) : m_regs[8];
        for (int p = 0; p < 4; p++) begin
            lat = m_latch[p*8 +: 8];
            case (wm)
                2'd0: src = m_regs[1][p] ? {8{m_regs[0][p]}} : rot;
                2'd2: src = {8{d[p]}};
                2'd3: src = {8{m_regs[0][p]}};
                default: src = rot;
            endcase
            case (fn)
                2'd1: alu = src & lat;
                2'd2: alu = src | lat;
                2'd3: alu = src ^ lat;
                default: alu = src;
            endcase
            out[p*8 +: 8] = (wm == 2'd1) ? lat : ((alu & emask) | (lat & ~emask));
        end
        return {m_regs[9][3:0], out};
    endfunction

    function automatic logic [7:0] mdl_read(input logic [31:0] planes);
        logic [7:0] r;
        if (m_regs[5][3]) begin
            for (int b = 0; b < 8; b++) begin
                r[b] = 1'b1;
                for (int p = 0; p < 4; p++)
                    if (m_regs[7][p] && (planes[p*8 + b] != m_regs[2][p])) r[b] = 1'b0;
            end
        end else begin
            r = planes[m_regs[4][1:0]*8 +: 8];
        end
        return r;
    endfunction

    // Monitor: compares each expected item in the cycle it falls due.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (!e.is_rd) begin
                    check({e.tag, " plane data"}, mem_wdata, e.data);
                    check({e.tag, " enables"}, {28'd0, mem_we}, {28'd0, e.we});
                    check({e.tag, " no read valid (R12)"}, {31'd0, host_rvalid}, 32'd0);
                    for (int p = 0; p < 4; p++)
                        if (mem_we[p]) mem[p][e.addr] = mem_wdata[p*8 +: 8];
                end else begin
                    check({e.tag, " valid"}, {31'd0, host_rvalid}, 32'd1);
                    check({e.tag, " read data"}, {24'd0, host_rdata}, e.data);
                end
            end else if (mem_we != 4'd0 || host_rvalid) begin
                check("R9 R10 idle outputs", {27'd0, host_rvalid, mem_we}, 32'd0);
            end
        end
    end

    task automatic set_reg(input int idx, input logic [7:0] val);
        @(negedge clk); idx_wr = 1'b1; bus_wdata = 8'(idx);
        @(negedge clk); idx_wr = 1'b0; data_wr = 1'b1; bus_wdata = val;
        @(negedge clk); data_wr = 1'b0;
        if (idx < 10) m_regs[idx] = val;
    endtask

    task automatic chk_reg(input int idx, input logic [7:0] exp, input string tag);
        @(negedge clk); idx_wr = 1'b1; bus_wdata = 8'(idx);
        @(negedge clk); idx_wr = 1'b0;
        check(tag, {24'd0, bus_rdata}, {24'd0, exp});
    endtask

    task automatic host_write(input int a, input logic [7:0] d, input string tag);
        exp_t e;
        logic [35:0] r;
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d;
        r = mdl_write(d);
        e.is_rd = 0; e.due = cyc + 1; e.data = r[31:0]; e.we = r[35:32]; e.addr = a; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(input int a, input string tag);
        exp_t e;
        @(negedge clk);
        host_rd = 1'b1;
        mem_rdata = {mem[3][a], mem[2][a], mem[1][a], mem[0][a]};
        e.is_rd = 1; e.due = cyc + 1; e.data = {24'd0, mdl_read(mem_rdata)}; e.we = '0; e.addr = a; e.tag = tag;
        m_latch = mem_rdata;
        sb.push_back(e);
        @(negedge clk); host_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic both_access(input int a, input logic [7:0] d);
        exp_t e;
        logic [35:0] r;
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_wdata = d;
        mem_rdata = {mem[3][a], mem[2][a], mem[1][a], mem[0][a]};
        r = mdl_write(d);
        e.is_rd = 0; e.due = cyc + 1; e.data = r[31:0]; e.we = r[35:32]; e.addr = a; e.tag = "R12 write wins";
        sb.push_back(e);
        @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        m_regs[8] = 8'hFF; m_regs[9] = 8'h0F;
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++) mem[p][a] = 8'(a * 37 + p * 91 + 5);

        repeat (4) @(negedge clk);
        check("R2 enables in reset", {28'd0, mem_we}, 32'd0);
        check("R2 rvalid in reset", {31'd0, host_rvalid}, 32'd0);
        rst_n = 1'b1;

        chk_reg(9, 8'h0F, "R2 plane enable");
        chk_reg(8, 8'hFF, "R2 bit mask");
        chk_reg(5, 8'h00, "R2 mode");
        chk_reg(3, 8'h00, "R2 rotate/function");
        chk_reg(1, 8'h00, "R2 colour enable");
        chk_reg(0, 8'h00, "R2 colour");

        set_reg(2, 8'h5A);
        chk_reg(2, 8'h5A, "R1 readback");
        set_reg(12, 8'h33);
        chk_reg(12, 8'h00, "R1 out-of-range read");
        chk_reg(2, 8'h5A, "R1 out-of-range write dropped");
        set_reg(2, 8'h00);

        for (int pl = 0; pl < 4; pl++) begin
            set_reg(4, 8'(pl));
            host_read(1, "R10 plane select");
        end

        host_write(2, 8'h96, "R3 plain");
        set_reg(3, 8'h03);
        host_write(3, 8'hB4, "R3 rotate");
        set_reg(1, 8'h05); set_reg(0, 8'h01);
        host_write(4, 8'h3C, "R3 colour substitute");
        set_reg(1, 8'h00); set_reg(0, 8'h00);

        host_read(5, "R4 latch load");
        set_reg(3, 8'h08);
        host_write(5, 8'hF0, "R4 and");
        host_read(6, "R4 latch load");
        set_reg(3, 8'h10);
        host_write(6, 8'h0F, "R4 or");
        set_reg(3, 8'h1A);
        host_write(6, 8'hA5, "R4 xor rotated");
        set_reg(3, 8'h00);

        host_read(7, "R8 latch load");
        set_reg(8, 8'h0F);
        host_write(7, 8'hFF, "R8 partial mask");
        set_reg(8, 8'hFF);

        set_reg(9, 8'h06);
        host_write(8, 8'h77, "R9 two planes");
        set_reg(9, 8'h00);
        host_write(8, 8'h11, "R9 no planes");
        set_reg(9, 8'h0F);

        host_read(9, "R5 latch load");
        set_reg(5, 8'h01); set_reg(8, 8'h00); set_reg(3, 8'h18);
        host_write(10, 8'h12, "R5 latch copy");
        set_reg(8, 8'hFF); set_reg(3, 8'h00); set_reg(5, 8'h00);

        host_read(11, "R6 latch load");
        set_reg(5, 8'h02);
        host_write(11, 8'h0A, "R6 colour expand");
        set_reg(8, 8'h3C);
        host_write(12, 8'h05, "R6 masked");
        set_reg(8, 8'hFF);

        set_reg(5, 8'h03); set_reg(0, 8'h09); set_reg(3, 8'h02);
        host_read(13, "R7 latch load");
        host_write(13, 8'hC3, "R7 masked colour");
        set_reg(5, 8'h00); set_reg(0, 8'h00); set_reg(3, 8'h00);

        set_reg(5, 8'h08); set_reg(2, 8'h0A); set_reg(7, 8'h0F);
        host_read(2, "R11 all planes");
        set_reg(7, 8'h05);
        host_read(3, "R11 partial care");
        set_reg(7, 8'h00);
        host_read(4, "R11 no care");
        set_reg(5, 8'h00);

        host_read(0, "R12 latch load");
        both_access(14, 8'h55);
        set_reg(5, 8'h01);
        host_write(15, 8'h00, "R12 latch unchanged");
        set_reg(5, 8'h00);

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++; n_err++;
            $display("FAIL R9 R10 pending items actual=%0d expected=0", sb.size());
        end
        finish_run();
    end
endmodule